// File: doc/BRIEF.md
# SCSI Bus Reset Controller

This block owns the SCSI RST line of a protocol controller. The host processor can assert RST by writing the reset bit of the command register. A timer keeps the line asserted for at least the minimum bus reset width, even if the host clears the bit too early. A host-driven reset aborts any command that is executing or queued. While RST is driven, it also releases every other SCSI output.

The block also watches the RST line of the bus. A rising edge that the block did not cause itself starts a fixed three-step sequence. First it pulses the command abort. On the next cycle it releases the other bus drivers. On the cycle after that it raises a non-maskable reset interrupt, which stays set until the host acknowledges it. A separate disable bit suppresses all reset handling. While the disable bit is set, the line is never driven and incoming resets are ignored.

The parameters `CLK_KHZ` and `MIN_US` give the clock rate and the minimum width. The drive lasts for at least `MIN_CYC = CLK_KHZ*MIN_US/1000 + 1` cycles.

Top module: `scsi_rst_ctrl`

## Requirements
- R1: After reset, `scsi_rst_drive`, `cmd_abort`, `bus_release` and `reset_nmi` are all 0.
- R2: A write (`cmd_wr`=1) with `cmd_rst_bit`=1 and `rst_disable`=0 sets `scsi_rst_drive` to 1 after that clock edge. The same edge produces a one-cycle `cmd_abort` pulse.
- R3: `bus_release` is 1 in every cycle in which `scsi_rst_drive` is 1.
- R4: Suppose the edge that writes 1 is followed L cycles later by an edge that writes 0. Then `scsi_rst_drive` is 1 for exactly max(L, MIN_CYC) cycles after the first edge.
- R5: Let the raw input `scsi_rst_in` rise before edge e1 while the drive is 0 and the block is enabled. Then `cmd_abort` is 1 for one cycle after e3. `bus_release` is 1 after e4. `reset_nmi` becomes 1 after e5.
- R6: After an accepted incoming reset, `bus_release` stays 1 while the synchronised input is high. If the input is high for W edges (e1..eW), `bus_release` is 1 after each edge e4..e(W+2) (at least e4), and 0 from then on.
- R7: `reset_nmi` stays 1 until the edge at which `irq_ack`=1, and is 0 after that edge. No enable exists for it.
- R8: While `rst_disable`=1, writes of the reset bit are discarded and `scsi_rst_drive` is 0. The timer is cleared. Incoming RST edges produce no `cmd_abort`, no `bus_release` and no `reset_nmi`. Clearing `rst_disable` afterwards does not revive a discarded write.
- R9: An incoming RST edge that arrives while the block itself drives RST produces no `reset_nmi` and no extra `cmd_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_disable | input | 1 | Global reset/disable bit; 1 suppresses all reset handling |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_rst_bit | input | 1 | Reset bit carried by the write |
| scsi_rst_in | input | 1 | Raw RST level seen on the SCSI bus |
| irq_ack | input | 1 | Acknowledge for the reset interrupt |
| scsi_rst_drive | output | 1 | Drives SCSI RST when 1 |
| cmd_abort | output | 1 | One-cycle pulse clearing current and queued command |
| bus_release | output | 1 | 1 deactivates all SCSI drivers other than RST |
| reset_nmi | output | 1 | Non-maskable reset interrupt flag |

## Verification
A host write shows on the drive and the abort after the edge that samples it. The drive then falls exactly max(L, MIN_CYC) edges later. An incoming reset passes through two synchroniser flops and an edge register, so abort, release and interrupt come due after the third, fourth and fifth edges. The bench drives every input at the falling clock edge and counts rising edges from the stimulus. At the falling edge after each rising edge it compares every output with a value computed from the edge index. It does this for every hold length from 1 to 40 and every input pulse width from 1 to 6.

// File: rtl/scsi_rst_ctrl.sv
module scsi_rst_ctrl #(
  parameter int CLK_KHZ = 125000,
  parameter int MIN_US  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_disable,
  input  logic cmd_wr,
  input  logic cmd_rst_bit,
  input  logic scsi_rst_in,
  input  logic irq_ack,
  output logic scsi_rst_drive,
  output logic cmd_abort,
  output logic bus_release,
  output logic reset_nmi
);

  localparam int MIN_CYC = (CLK_KHZ * MIN_US) / 1000 + 1;
  localparam int CW      = $clog2(MIN_CYC + 1);

  logic          host_bit;
  logic [CW-1:0] hold_cnt;
  logic [2:0]    sync_q;
  logic          ext_p1, ext_p2, ext_hold;
  logic          abort_q, nmi_q;

  wire host_set = cmd_wr & cmd_rst_bit & ~rst_disable;
  wire ext_edge = sync_q[1] & ~sync_q[2];
  wire ext_acc  = ext_edge & ~rst_disable & ~scsi_rst_drive;

  assign scsi_rst_drive = ~rst_disable & (host_bit | (hold_cnt != '0));
  assign bus_release    = ~rst_disable & (scsi_rst_drive | ext_hold);
  assign cmd_abort      = abort_q;
  assign reset_nmi      = nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_bit <= 1'b0;
      hold_cnt <= '0;
    end else if (rst_disable) begin
      host_bit <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (cmd_wr) host_bit <= cmd_rst_bit;
      if (host_set)             hold_cnt <= CW'(MIN_CYC);
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], scsi_rst_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q  <= 1'b0;
      ext_p1   <= 1'b0;
      ext_p2   <= 1'b0;
      ext_hold <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      abort_q  <= host_set | ext_acc;
      ext_p1   <= ext_acc;
      ext_p2   <= ext_p1 & ~rst_disable;
      ext_hold <= ~rst_disable & (ext_p1 | (ext_hold & sync_q[1]));
      nmi_q    <= (ext_p2 & ~rst_disable) | (nmi_q & ~irq_ack);
    end
  end

  // R2: every new host drive is accompanied by the command abort
  p_drive_aborts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scsi_rst_drive) |-> cmd_abort);

  // R3: other drivers released while RST is driven
  p_release_with_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_rst_drive |-> bus_release);

  // R5: interrupt only follows a cycle of released drivers
  p_nmi_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_nmi) |-> $past(bus_release));

  // R7: interrupt is sticky until acknowledged
  p_nmi_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_nmi && !irq_ack) |=> reset_nmi);

  // R8: no new interrupt when the previous cycle was disabled
  p_disable_no_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_disable |=> !$rose(reset_nmi));

  // R9: own drive never produces an interrupt edge
  p_own_drive_no_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scsi_rst_drive) && scsi_rst_drive && !ext_p2) |-> !$rose(reset_nmi));

endmodule

// File: tb/test_scsi_rst_ctrl.sv
module test_scsi_rst_ctrl;
  localparam int KHZ = 1000;
  localparam int US  = 25;
  localparam int N   = KHZ * US / 1000 + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_disable = 1'b0, cmd_wr = 1'b0, cmd_rst_bit = 1'b0;
  logic scsi_rst_in = 1'b0, irq_ack = 1'b0;
  logic scsi_rst_drive, cmd_abort, bus_release, reset_nmi;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scsi_rst_ctrl #(.CLK_KHZ(KHZ), .MIN_US(US)) i_scsi_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_disable(rst_disable), .cmd_wr(cmd_wr),
    .cmd_rst_bit(cmd_rst_bit), .scsi_rst_in(scsi_rst_in), .irq_ack(irq_ack),
    .scsi_rst_drive(scsi_rst_drive), .cmd_abort(cmd_abort),
    .bus_release(bus_release), .reset_nmi(reset_nmi));

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_nmi();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    idle(2);
    chk(scsi_rst_drive, 1'b0, "R1 drive");
    chk(cmd_abort, 1'b0, "R1 abort");
    chk(bus_release, 1'b0, "R1 release");
    chk(reset_nmi, 1'b0, "R1 nmi");
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4: hold-length sweep
    for (int L = 1; L <= 40; L++) begin
      cmd_wr = 1'b1; cmd_rst_bit = 1'b1;
      for (int k = 0; k < 46; k++) begin
        @(negedge clk);
        chk(scsi_rst_drive, (k < ((L > N) ? L : N)) ? 1'b1 : 1'b0, "R4 width");
        chk(bus_release, (k < ((L > N) ? L : N)) ? 1'b1 : 1'b0, "R3 release");
        chk(cmd_abort, (k == 0) ? 1'b1 : 1'b0, "R2 abort");
        if (k == L - 1) begin cmd_wr = 1'b1; cmd_rst_bit = 1'b0; end
        else cmd_wr = 1'b0;
      end
      chk(reset_nmi, 1'b0, "R2 no nmi");
    end
    idle(3);

    // R5 R6 R7: incoming pulse width sweep
    for (int W = 1; W <= 6; W++) begin
      scsi_rst_in = 1'b1;
      for (int j = 1; j <= 10; j++) begin
        @(negedge clk);
        if (j == W) scsi_rst_in = 1'b0;
        chk(cmd_abort, (j == 3) ? 1'b1 : 1'b0, "R5 abort");
        chk(bus_release, (j == 4 || (j >= 5 && j <= W + 2)) ? 1'b1 : 1'b0, "R6 release");
        chk(reset_nmi, (j >= 5) ? 1'b1 : 1'b0, "R5 nmi");
        chk(scsi_rst_drive, 1'b0, "R5 no drive");
      end
      idle(4);
      chk(reset_nmi, 1'b1, "R7 sticky");
      ack_nmi();
      chk(reset_nmi, 1'b0, "R7 cleared");
      idle(2);
    end

    // R8: disabled
    rst_disable = 1'b1;
    cmd_wr = 1'b1; cmd_rst_bit = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    scsi_rst_in = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk(scsi_rst_drive, 1'b0, "R8 drive");
      chk(cmd_abort, 1'b0, "R8 abort");
      chk(bus_release, 1'b0, "R8 release");
      chk(reset_nmi, 1'b0, "R8 nmi");
    end
    scsi_rst_in = 1'b0;
    idle(4);
    rst_disable = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(scsi_rst_drive, 1'b0, "R8 no revive");
      chk(cmd_abort, 1'b0, "R8 no late abort");
    end

    // R9: incoming edge during own drive
    cmd_wr = 1'b1; cmd_rst_bit = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    scsi_rst_in = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk(cmd_abort, 1'b0, "R9 abort");
      chk(reset_nmi, 1'b0, "R9 nmi");
      chk(scsi_rst_drive, 1'b1, "R9 drive");
    end
    cmd_wr = 1'b1; cmd_rst_bit = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b0;
    scsi_rst_in = 1'b0;
    idle(N + 4);
    chk(reset_nmi, 1'b0, "R9 nmi after");
    chk(scsi_rst_drive, 1'b0, "R4 drive ended");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule